// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox

This block lets any of NCPU processors post a numbered interrupt to another processor, or to every processor but one, through a single shared request port. The port carries the ID of the processor making the access. Each processor owns a queue of pending interrupt numbers and an interrupt line. The line stays high while that queue holds anything.

A processor takes an interrupt by reading the mailbox register. The read hands back the oldest pending number and removes it from the queue. An empty queue reads as zero, so number zero is never used for a real interrupt. Writing the mailbox register discards the whole queue of the processor that wrote it.

Send requests go through one registered dispatch stage before they reach the queues. The last-level fan-out to all processors therefore starts from a register. As a result, a send and a later read or flush can land on the same queue at the same clock edge, and the block defines how such collisions resolve. A queue that is full drops further numbers and raises a sticky per-processor overflow flag.

Top module: `ipi_mailbox`

## Requirements
- R1: A send word holds the interrupt number in bits 31:16 and a target index in bits 15:0. A write with `req_op` = 0 (send-one) enqueues the number only for the processor whose index matches.
- R2: A write with `req_op` = 1 (send-all-but) enqueues the number for every processor except the indexed one.
- R3: Queues are first-in first-out. A read with `req_op` = 2 and `req_write` = 0 returns the oldest number of the accessing processor in `rd_data[15:0]`, with bits 31:16 zero, and removes that entry. `rd_valid` pulses for one cycle.
- R4: A read of an empty queue returns 0 and leaves every queue unchanged.
- R5: A write with `req_op` = 2 empties the queue of the accessing processor and leaves the other queues unchanged.
- R6: `irq[i]` is high exactly when queue i is non-empty. A send sampled at clock edge k is visible in the queues and in `irq` after edge k+1. Read data and pops take effect at the edge that samples the read.
- R7: A number sent to a full queue is dropped, and `ovf[i]` of that processor is set and stays set until reset.
- R8: When a dispatched send and a pop reach the same queue at one edge, both apply and the entry count is unchanged. A full queue that is popped at that edge accepts the new number without overflow.
- R9: When a dispatched send and a flush reach the same queue at one edge, the older entries are discarded and the arriving number is kept.
- R10: A send-one whose index names no processor has no effect. Requests with `req_op` = 3 are ignored.
- R11: After reset all queues are empty, and `irq`, `ovf`, `rd_valid` and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op | input | 2 | 0 send-one, 1 send-all-but, 2 mailbox, 3 unused |
| req_cpu | input | ID_W | Index of the accessing processor |
| req_wdata | input | 32 | Write data: number in 31:16, target index in 15:0 |
| rd_valid | output | 1 | One-cycle pulse after a mailbox read |
| rd_data | output | 32 | Number popped by the last read, or 0 if the queue was empty |
| irq | output | NCPU | Per-processor interrupt line |
| ovf | output | NCPU | Per-processor sticky overflow flag |

## Verification
The bench targets the edges where a staged send meets a read or flush on the same queue. It checks that a read one cycle after a send to an empty queue returns zero while the number still arrives. A design that popped the new entry, or lost it, fails that check. It fills a queue to exactly its depth and sends once more, once without and once with a simultaneous pop. An off-by-one in the full test would either corrupt the oldest entry or raise overflow wrongly. It also checks that a flush colliding with an arriving number keeps that number, and that an out-of-range send-one index wakes nobody.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int WORD_W = 32;
  localparam int NUM_W  = 16;
  localparam int IDX_W  = 16;

  typedef enum logic [1:0] {
    OP_SEND_ONE = 2'd0,
    OP_SEND_BUT = 2'd1,
    OP_MAILBOX  = 2'd2,
    OP_UNUSED   = 2'd3
  } ipi_op_e;
endpackage

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
  import ipi_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_op,
  input  logic [WORD_W-1:0] req_wdata,
  output logic [NCPU-1:0]   stg_mask,
  output logic [NUM_W-1:0]  stg_num
);
  logic             is_one, is_but;
  logic [IDX_W-1:0] tgt;
  logic [NCPU-1:0]  mask_nxt;

  assign is_one = req_valid && req_write && (req_op == OP_SEND_ONE);
  assign is_but = req_valid && req_write && (req_op == OP_SEND_BUT);
  assign tgt    = req_wdata[IDX_W-1:0];

  for (genvar i = 0; i < NCPU; i++) begin : g_dec
    logic hit;
    assign hit         = (tgt == IDX_W'(i));
    assign mask_nxt[i] = (is_one && hit) || (is_but && !hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_mask <= '0;
      stg_num  <= '0;
    end else begin
      stg_mask <= mask_nxt;
      stg_num  <= req_wdata[WORD_W-1:IDX_W];
    end
  end

  // R1
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_op == OP_SEND_ONE) |=> $onehot0(stg_mask));

  // R10
  unused_op_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_UNUSED) |=> (stg_mask == '0));
endmodule

// File: rtl/ipi_queue.sv
module ipi_queue
  import ipi_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [NUM_W-1:0] din,
  input  logic             pop,
  input  logic             flush,
  output logic [NUM_W-1:0] head,
  output logic             empty,
  output logic             ovf
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [NUM_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;
  logic             full, do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_pop  = pop && !empty && !flush;
  assign do_push = push && (flush || !full || do_pop);
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (push && !do_push) ovf <= 1'b1;
      if (flush) begin
        rp  <= wp;
        cnt <= CNT_W'(do_push);
        if (do_push) wp <= bump(wp);
      end else begin
        if (do_push) wp <= bump(wp);
        if (do_pop)  rp <= bump(rp);
        cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
      end
    end
  end

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  // R5
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (flush && !push) |=> empty);

  // R8
  push_pop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !flush && !empty) |=> $stable(cnt));
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
  import ipi_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int DEPTH = 4,
  parameter int ID_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_op,
  input  logic [ID_W-1:0]   req_cpu,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic [NCPU-1:0]   irq,
  output logic [NCPU-1:0]   ovf
);
  logic [NCPU-1:0]  stg_mask;
  logic [NUM_W-1:0] stg_num;
  logic [NUM_W-1:0] heads [NCPU];
  logic [NCPU-1:0]  empty;
  logic             mb_rd, mb_wr;
  logic [NUM_W-1:0] sel_head;

  assign mb_rd = req_valid && !req_write && (req_op == OP_MAILBOX);
  assign mb_wr = req_valid &&  req_write && (req_op == OP_MAILBOX);

  ipi_dispatch #(.NCPU(NCPU)) u_disp (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_op    (req_op),
    .req_wdata (req_wdata),
    .stg_mask  (stg_mask),
    .stg_num   (stg_num)
  );

  for (genvar i = 0; i < NCPU; i++) begin : g_q
    logic me;
    assign me = (req_cpu == ID_W'(i));
    ipi_queue #(.DEPTH(DEPTH)) u_q (
      .clk   (clk),
      .rst   (rst),
      .push  (stg_mask[i]),
      .din   (stg_num),
      .pop   (mb_rd && me),
      .flush (mb_wr && me),
      .head  (heads[i]),
      .empty (empty[i]),
      .ovf   (ovf[i])
    );
    assign irq[i] = !empty[i];
  end

  always_comb begin
    sel_head = '0;
    for (int i = 0; i < NCPU; i++)
      if (req_cpu == ID_W'(i) && !empty[i]) sel_head = heads[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= mb_rd;
      if (mb_rd) rd_data <= {{(WORD_W-NUM_W){1'b0}}, sel_head};
    end
  end

  // R3
  rd_valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(mb_rd));

  // R6
  irq_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (stg_mask != '0) |=> ((irq & $past(stg_mask)) == $past(stg_mask)));
endmodule

// File: tb/tb_ipi_mailbox.sv
module tb_ipi_mailbox;
  localparam int NCPU = 4;
  localparam int DEPTH = 4;
  localparam int ID_W = 2;

  logic        clk = 0;
  logic        rst = 1;
  logic        req_valid = 0, req_write = 0;
  logic [1:0]  req_op = 0;
  logic [1:0]  req_cpu = 0;
  logic [31:0] req_wdata = 0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [3:0]  irq, ovf;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ipi_mailbox #(.NCPU(NCPU), .DEPTH(DEPTH), .ID_W(ID_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_op(req_op), .req_cpu(req_cpu), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq), .ovf(ovf)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  cpu;
    logic        wr;
    logic [31:0] wdata;
    logic        chk_rd;
    logic [31:0] exp_rd;
    logic [3:0]  exp_irq;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'd0, 1'b1, {16'd5, 16'd2}, 1'b0, 32'd0, 4'b0100},
    '{2'd1, 2'd0, 1'b1, {16'd7, 16'd2}, 1'b0, 32'd0, 4'b1111},
    '{2'd0, 2'd0, 1'b1, {16'd9, 16'd2}, 1'b0, 32'd0, 4'b1111},
    '{2'd2, 2'd2, 1'b0, 32'd0,          1'b1, 32'd5, 4'b1111},
    '{2'd2, 2'd2, 1'b0, 32'd0,          1'b1, 32'd9, 4'b1011},
    '{2'd2, 2'd2, 1'b0, 32'd0,          1'b1, 32'd0, 4'b1011},
    '{2'd2, 2'd0, 1'b1, 32'd0,          1'b0, 32'd0, 4'b1010},
    '{2'd2, 2'd1, 1'b0, 32'd0,          1'b1, 32'd7, 4'b1000},
    '{2'd0, 2'd0, 1'b1, {16'd3, 16'd7}, 1'b0, 32'd0, 4'b1000},
    '{2'd2, 2'd3, 1'b0, 32'd0,          1'b1, 32'd7, 4'b0000},
    '{2'd3, 2'd1, 1'b1, {16'd4, 16'd1}, 1'b0, 32'd0, 4'b0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic req(input logic [1:0] op, input logic [1:0] cpu, input logic wr,
                     input logic [31:0] wd);
    req_valid = 1; req_op = op; req_cpu = cpu; req_write = wr; req_wdata = wd;
    @(negedge clk);
  endtask

  task automatic idle();
    req_valid = 0; req_write = 0;
    @(negedge clk);
  endtask

  task automatic send(input logic [1:0] op, input logic [15:0] num, input logic [15:0] idx);
    req(op, 2'd0, 1'b1, {num, idx});
  endtask

  task automatic rd(input logic [1:0] cpu, input logic [31:0] exp, input string tag);
    req(2'd2, cpu, 1'b0, 32'd0);
    chk(tag, rd_data, exp);
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset state
    chk("R11 irq", {28'd0, irq}, 32'd0);
    chk("R11 ovf", {28'd0, ovf}, 32'd0);
    chk("R11 rd_data", rd_data, 32'd0);
    chk("R11 rd_valid", {31'd0, rd_valid}, 32'd0);

    // Table: R1 R2 R3 R4 R5 R6 R10
    for (int v = 0; v < NV; v++) begin
      req(VEC[v].op, VEC[v].cpu, VEC[v].wr, VEC[v].wdata);
      if (VEC[v].chk_rd) chk($sformatf("R3/R4 vec%0d rd_valid", v), {31'd0, rd_valid}, 32'd1);
      idle();
      if (VEC[v].chk_rd) chk($sformatf("R3/R4 vec%0d rd_data", v), rd_data, VEC[v].exp_rd);
      chk($sformatf("R1/R2/R5/R6/R10 vec%0d irq", v), {28'd0, irq}, {28'd0, VEC[v].exp_irq});
    end
    chk("R10 ovf after table", {28'd0, ovf}, 32'd0);

    // R6 timing: send sampled at edge k, irq visible only after edge k+1
    send(2'd0, 16'h21, 16'd1);
    chk("R6 irq not yet", {28'd0, irq}, 32'd0);
    idle();
    chk("R6 irq now", {28'd0, irq}, 32'h2);
    rd(2'd1, 32'h21, "R6 drain");

    // R7 overflow on cpu1
    for (int k = 1; k <= DEPTH + 1; k++) send(2'd0, 16'(k), 16'd1);
    idle(); idle();
    chk("R7 ovf set", {28'd0, ovf}, 32'h2);
    for (int k = 1; k <= DEPTH; k++) rd(2'd1, 32'(k), "R7 kept entries");
    rd(2'd1, 32'd0, "R7 extra dropped");
    chk("R7 ovf sticky", {28'd0, ovf}, 32'h2);

    // R8 send then read next cycle on empty queue: read sees empty
    send(2'd0, 16'h11, 16'd0);
    req(2'd2, 2'd0, 1'b0, 32'd0);
    chk("R8 read before arrival", rd_data, 32'd0);
    idle();
    chk("R8 irq after arrival", {28'd0, irq}, 32'h1);
    // queue0 = [11]; send 12 and pop at same edge
    send(2'd0, 16'h12, 16'd0);
    req(2'd2, 2'd0, 1'b0, 32'd0);
    chk("R8 pop head", rd_data, 32'h11);
    idle();
    chk("R8 irq held", {28'd0, irq}, 32'h1);
    rd(2'd0, 32'h12, "R8 new entry");
    rd(2'd0, 32'd0, "R8 count unchanged");

    // R8 full queue with simultaneous pop accepts
    for (int k = 1; k <= DEPTH; k++) send(2'd0, 16'(k + 16'h30), 16'd3);
    idle();
    send(2'd0, 16'h3F, 16'd3);
    req(2'd2, 2'd3, 1'b0, 32'd0);
    chk("R8 full pop head", rd_data, 32'h31);
    idle();
    chk("R8 no overflow", {28'd0, ovf}, 32'h2);
    for (int k = 2; k <= DEPTH; k++) rd(2'd3, 32'(k + 32'h30), "R8 full order");
    rd(2'd3, 32'h3F, "R8 full accepted");

    // R9 flush colliding with arriving send
    send(2'd0, 16'h40, 16'd2);
    idle();
    send(2'd0, 16'h41, 16'd2);
    req(2'd2, 2'd2, 1'b1, 32'd0);
    idle();
    chk("R9 irq kept", {28'd0, irq}, 32'h4);
    rd(2'd2, 32'h41, "R9 arriving kept");
    rd(2'd2, 32'd0, "R9 older gone");

    finish_run();
  end
endmodule